// File: doc/BRIEF.md
# AXI4 Burst to AXI4-Lite Write Converter

This block sits between an AXI4 master and a cluster of AXI4-Lite slaves and carries only the write path. It is an AXI4 slave on the write address, write data and write response channels. It replays each burst as a chain of single-beat AXI4-Lite writes, and it walks the beat addresses itself for fixed, incrementing and wrapping bursts. It handles one burst at a time. The next burst is admitted only after the response of the previous one has been taken.

The wide side may carry more data bits than the narrow side. In that case each wide beat becomes several narrow writes, one for each narrow lane slot that the beat touches. Each narrow write carries the bytes and strobes of its own slot, in little-endian lane order. The narrow responses of a burst are folded into one response, and the burst's ID is returned with it. When both data widths match, the slot logic is left out by generate, each beat produces one narrow write, and error codes pass through unchanged.

Top module: `axi_wr_narrow`

## Requirements
- R1: Only one burst is in flight. `s_awready` is high only when the block is idle, and after an address handshake it stays low until the write response handshake has completed.
- R2: `s_bid` equals the `s_awid` captured at the address handshake of the same burst.
- R3: The narrow address is the low NA_W bits of the child address. The first child of a beat carries the beat address as it is. Each further child carries its slot base, which is the slot index times the narrow byte count.
- R4: With a wider AXI4 side, a beat of 2^size bytes gives one child for each narrow slot from the slot holding the beat address up to the end of the size-aligned container of that beat, issued in ascending slot order. No further wide data beat is accepted until the last child's response is taken.
- R5: For slot k (address bits [log2(WD_W/8)-1 : log2(ND_W/8)]), the narrow data is `wdata[k*ND_W +: ND_W]` and the narrow strobe is `wstrb[k*ND_W/8 +: ND_W/8]`.
- R6: Burst code 2'b01 (incrementing): the next beat address is the current address aligned down to 2^size, plus 2^size.
- R7: Burst code 2'b00 (fixed): every beat uses the start address.
- R8: Burst code 2'b10 (wrapping): the container is (len+1)·2^size bytes, aligned down from the start address. A beat address that reaches the container's upper end returns to its base.
- R9: With differing widths, an error response (2'b10 or 2'b11) on any child makes the burst response 2'b10, and this holds for the rest of the burst. Otherwise the response is 2'b00. The burst response and ID are held while they wait for `s_bready`.
- R10: With equal widths, each beat gives exactly one narrow write carrying the beat's data and strobes unchanged. The burst response is the first non-OKAY narrow response, unchanged (2'b11 stays 2'b11), or 2'b00 if every child returned OKAY.
- R11: `s_awprot` of the burst appears on `m_awprot` for every child.
- R12: A child's narrow address and data are both offered, and each is held until accepted. `m_bready` rises only after both have been accepted. No new child is offered before the previous child's response has been taken.
- R13: Reset is synchronous and active-low. It returns the block to idle with `s_awready` high and `s_bvalid`, `m_awvalid` and `m_wvalid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_awvalid | input | 1 | Wide write address valid |
| s_awready | output | 1 | Wide write address ready |
| s_awid | input | ID_W | Burst ID |
| s_awaddr | input | WA_W | Burst start address |
| s_awlen | input | 8 | Beats minus one |
| s_awsize | input | 3 | log2 of bytes per beat |
| s_awburst | input | 2 | Burst kind: 00 fixed, 01 incrementing, 10 wrapping |
| s_awprot | input | 3 | Protection attributes |
| s_wvalid | input | 1 | Wide write data valid |
| s_wready | output | 1 | Wide write data ready |
| s_wdata | input | WD_W | Wide write data |
| s_wstrb | input | WD_W/8 | Wide byte strobes |
| s_bvalid | output | 1 | Burst response valid |
| s_bready | input | 1 | Burst response ready |
| s_bid | output | ID_W | Returned burst ID |
| s_bresp | output | 2 | Folded burst response |
| m_awvalid | output | 1 | Narrow write address valid |
| m_awready | input | 1 | Narrow write address ready |
| m_awaddr | output | NA_W | Narrow write address |
| m_awprot | output | 3 | Narrow protection attributes |
| m_wvalid | output | 1 | Narrow write data valid |
| m_wready | input | 1 | Narrow write data ready |
| m_wdata | output | ND_W | Narrow write data |
| m_wstrb | output | ND_W/8 | Narrow byte strobes |
| m_bvalid | input | 1 | Narrow response valid |
| m_bready | output | 1 | Narrow response ready |
| m_bresp | input | 2 | Narrow response code |

## Verification
The bench aims at beats whose start address is not aligned. There the first child must keep the offset and later children must snap to their slot base, so a slot walk that starts at lane zero sends bytes to the wrong narrow address. Wrapping bursts that begin mid-container check the return to base, and an off-by-one boundary runs past the container instead of folding back. Narrow beats smaller than one narrow slot must give exactly one child, because a miscounted last slot adds or drops a write. Forced error responses on single children check that one DECERR in a split burst still yields SLVERR at the end, while an equal-width instance must return DECERR as it arrived.

// File: rtl/axwn_pkg.sv
package axwn_pkg;

   typedef enum logic [1:0] {
      BURST_FIXED = 2'b00,
      BURST_INCR  = 2'b01,
      BURST_WRAP  = 2'b10
   } burst_e;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_BEAT,
      PH_CHILD,
      PH_CRESP,
      PH_BRESP
   } phase_e;

   localparam logic [1:0] RESP_OKAY   = 2'b00;
   localparam logic [1:0] RESP_SLVERR = 2'b10;
   localparam logic [1:0] RESP_DECERR = 2'b11;

endpackage

// File: rtl/axwn_addr_step.sv
module axwn_addr_step
   import axwn_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic [AW-1:0] cur_addr,
   input  logic [2:0]    size,
   input  logic [1:0]    burst,
   input  logic [AW-1:0] wrap_base,
   input  logic [AW-1:0] wrap_mask,
   output logic [AW-1:0] nxt_addr
);
   logic [AW-1:0] step;
   logic [AW-1:0] aligned;
   logic [AW-1:0] bumped;

   always_comb begin
      step    = AW'(1) << size;
      aligned = cur_addr & ~(step - AW'(1));
      bumped  = aligned + step;
      case (burst)
         BURST_FIXED: nxt_addr = cur_addr;
         BURST_WRAP:  nxt_addr = wrap_base | (bumped & wrap_mask);
         default:     nxt_addr = bumped;
      endcase
   end
endmodule

// File: rtl/axwn_lane_pick.sv
module axwn_lane_pick #(
   parameter int WD_W = 32,
   parameter int ND_W = 16,
   localparam int NSB  = ND_W / 8,
   localparam int SL_W = $clog2(WD_W / ND_W)
) (
   input  logic [WD_W-1:0]   wdata,
   input  logic [WD_W/8-1:0] wstrb,
   input  logic [SL_W-1:0]   slot,
   output logic [ND_W-1:0]   ndata,
   output logic [NSB-1:0]    nstrb
);
   assign ndata = wdata[slot*ND_W +: ND_W];
   assign nstrb = wstrb[slot*NSB +: NSB];
endmodule

// File: rtl/axwn_resp_fold.sv
module axwn_resp_fold
   import axwn_pkg::*;
#(
   parameter bit SPLIT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       upd,
   input  logic [1:0] resp_in,
   output logic [1:0] resp_out
);
   logic [1:0] acc_q;

   generate
      if (SPLIT) begin : g_sticky
         always_ff @(posedge clk) begin
            if (!rst_n || clr)
               acc_q <= RESP_OKAY;
            else if (upd && (resp_in == RESP_SLVERR || resp_in == RESP_DECERR))
               acc_q <= RESP_SLVERR;
         end
      end else begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n || clr)
               acc_q <= RESP_OKAY;
            else if (upd && acc_q == RESP_OKAY)
               acc_q <= resp_in;
         end
      end
   endgenerate

   assign resp_out = acc_q;
endmodule

// File: rtl/axi_wr_narrow.sv
module axi_wr_narrow
   import axwn_pkg::*;
#(
   parameter int ID_W = 4,
   parameter int WA_W = 32,
   parameter int NA_W = 24,
   parameter int WD_W = 32,
   parameter int ND_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_awvalid,
   output logic              s_awready,
   input  logic [ID_W-1:0]   s_awid,
   input  logic [WA_W-1:0]   s_awaddr,
   input  logic [7:0]        s_awlen,
   input  logic [2:0]        s_awsize,
   input  logic [1:0]        s_awburst,
   input  logic [2:0]        s_awprot,
   input  logic              s_wvalid,
   output logic              s_wready,
   input  logic [WD_W-1:0]   s_wdata,
   input  logic [WD_W/8-1:0] s_wstrb,
   output logic              s_bvalid,
   input  logic              s_bready,
   output logic [ID_W-1:0]   s_bid,
   output logic [1:0]        s_bresp,
   output logic              m_awvalid,
   input  logic              m_awready,
   output logic [NA_W-1:0]   m_awaddr,
   output logic [2:0]        m_awprot,
   output logic              m_wvalid,
   input  logic              m_wready,
   output logic [ND_W-1:0]   m_wdata,
   output logic [ND_W/8-1:0] m_wstrb,
   input  logic              m_bvalid,
   output logic              m_bready,
   input  logic [1:0]        m_bresp
);
   localparam int WSB   = WD_W / 8;
   localparam int NSB   = ND_W / 8;
   localparam int RATIO = WD_W / ND_W;
   localparam int WOFF  = $clog2(WSB);
   localparam int NOFF  = $clog2(NSB);
   localparam bit SPLIT = (RATIO > 1);

   generate
      if (WA_W < NA_W)              begin : g_bad_addr  $error("wide address narrower than narrow address"); end
      if (WD_W < ND_W)              begin : g_bad_data  $error("wide data narrower than narrow data"); end
      if (WD_W % 8 != 0 || ND_W % 8 != 0) begin : g_bad_bytes $error("data widths must be whole bytes"); end
      if ((1 << WOFF) != WSB || (1 << NOFF) != NSB) begin : g_bad_pow2 $error("data widths must be power-of-two bytes"); end
      if (NA_W <= WOFF)             begin : g_bad_na    $error("narrow address too small for lane offset"); end
      if (WA_W < 16)                begin : g_bad_wa    $error("wide address must hold a full wrap container"); end
   endgenerate

   phase_e            phase_q;
   logic [ID_W-1:0]   id_q;
   logic [WA_W-1:0]   addr_q;
   logic [WA_W-1:0]   wbase_q;
   logic [WA_W-1:0]   wmask_q;
   logic [7:0]        len_q;
   logic [7:0]        beat_q;
   logic [2:0]        size_q;
   logic [1:0]        burst_q;
   logic [2:0]        prot_q;
   logic [WD_W-1:0]   wdata_q;
   logic [WSB-1:0]    wstrb_q;
   logic              aw_done_q;
   logic              w_done_q;

   logic [WA_W-1:0]   nxt_addr;
   logic [WA_W-1:0]   aw_total;
   logic [WA_W-1:0]   aw_mask;
   logic              aw_fire, w_fire, lb_fire, sb_fire;
   logic              aw_ok, w_ok;
   logic              more_child;

   assign s_awready = (phase_q == PH_IDLE);
   assign s_wready  = (phase_q == PH_BEAT);
   assign s_bvalid  = (phase_q == PH_BRESP);
   assign m_awvalid = (phase_q == PH_CHILD) && !aw_done_q;
   assign m_wvalid  = (phase_q == PH_CHILD) && !w_done_q;
   assign m_bready  = (phase_q == PH_CRESP);
   assign s_bid     = id_q;
   assign m_awprot  = prot_q;

   assign aw_fire = s_awvalid && s_awready;
   assign w_fire  = s_wvalid && s_wready;
   assign lb_fire = m_bvalid && m_bready;
   assign sb_fire = s_bvalid && s_bready;
   assign aw_ok   = aw_done_q || m_awready;
   assign w_ok    = w_done_q || m_wready;

   assign aw_total = (WA_W'(s_awlen) + WA_W'(1)) << s_awsize;
   assign aw_mask  = aw_total - WA_W'(1);

   axwn_addr_step #(.AW(WA_W)) u_step (
      .cur_addr  (addr_q),
      .size      (size_q),
      .burst     (burst_q),
      .wrap_base (wbase_q),
      .wrap_mask (wmask_q),
      .nxt_addr  (nxt_addr)
   );

   axwn_resp_fold #(.SPLIT(SPLIT)) u_fold (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (aw_fire),
      .upd      (lb_fire),
      .resp_in  (m_bresp),
      .resp_out (s_bresp)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         id_q      <= '0;
         addr_q    <= '0;
         wbase_q   <= '0;
         wmask_q   <= '0;
         len_q     <= '0;
         beat_q    <= '0;
         size_q    <= '0;
         burst_q   <= '0;
         prot_q    <= '0;
         wdata_q   <= '0;
         wstrb_q   <= '0;
         aw_done_q <= 1'b0;
         w_done_q  <= 1'b0;
      end else begin
         case (phase_q)
            PH_IDLE: if (aw_fire) begin
               id_q    <= s_awid;
               addr_q  <= s_awaddr;
               wbase_q <= s_awaddr & ~aw_mask;
               wmask_q <= aw_mask;
               len_q   <= s_awlen;
               beat_q  <= '0;
               size_q  <= s_awsize;
               burst_q <= s_awburst;
               prot_q  <= s_awprot;
               phase_q <= PH_BEAT;
            end
            PH_BEAT: if (w_fire) begin
               wdata_q <= s_wdata;
               wstrb_q <= s_wstrb;
               phase_q <= PH_CHILD;
            end
            PH_CHILD: begin
               if (aw_ok && w_ok) begin
                  aw_done_q <= 1'b0;
                  w_done_q  <= 1'b0;
                  phase_q   <= PH_CRESP;
               end else begin
                  aw_done_q <= aw_ok;
                  w_done_q  <= w_ok;
               end
            end
            PH_CRESP: if (lb_fire) begin
               if (more_child)
                  phase_q <= PH_CHILD;
               else if (beat_q == len_q)
                  phase_q <= PH_BRESP;
               else begin
                  beat_q  <= beat_q + 8'd1;
                  addr_q  <= nxt_addr;
                  phase_q <= PH_BEAT;
               end
            end
            PH_BRESP: if (sb_fire) phase_q <= PH_IDLE;
            default:  phase_q <= PH_IDLE;
         endcase
      end
   end

   generate
      if (SPLIT) begin : g_split
         localparam int SL_W = WOFF - NOFF;
         localparam int CW   = WOFF + 1;
         logic [SL_W-1:0] slot_q;
         logic [SL_W-1:0] last_q;
         logic            first_q;
         logic [CW-1:0]   step_w, cbase, lastb;
         logic [NA_W-1:0] slot_base;

         always_comb begin
            step_w = CW'(1) << size_q;
            cbase  = {1'b0, addr_q[WOFF-1:0]} & ~(step_w - CW'(1));
            lastb  = cbase + step_w - CW'(1);
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               slot_q  <= '0;
               last_q  <= '0;
               first_q <= 1'b1;
            end else if (w_fire) begin
               slot_q  <= SL_W'(addr_q[WOFF-1:0] >> NOFF);
               last_q  <= SL_W'(lastb >> NOFF);
               first_q <= 1'b1;
            end else if (lb_fire && more_child) begin
               slot_q  <= slot_q + SL_W'(1);
               first_q <= 1'b0;
            end
         end

         assign more_child = (slot_q != last_q);
         assign slot_base  = NA_W'({addr_q[NA_W-1:WOFF], slot_q}) << NOFF;
         assign m_awaddr   = first_q ? addr_q[NA_W-1:0] : slot_base;

         axwn_lane_pick #(.WD_W(WD_W), .ND_W(ND_W)) u_pick (
            .wdata (wdata_q),
            .wstrb (wstrb_q),
            .slot  (slot_q),
            .ndata (m_wdata),
            .nstrb (m_wstrb)
         );
      end else begin : g_flat
         assign more_child = 1'b0;
         assign m_awaddr   = addr_q[NA_W-1:0];
         assign m_wdata    = wdata_q;
         assign m_wstrb    = wstrb_q;
      end
   endgenerate
endmodule

// File: rtl/axwn_chk.sv
module axwn_chk #(
   parameter int ID_W  = 4,
   parameter int NA_W  = 24,
   parameter bit SPLIT = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            s_awvalid,
   input logic            s_awready,
   input logic [ID_W-1:0] s_awid,
   input logic            s_bvalid,
   input logic            s_bready,
   input logic [ID_W-1:0] s_bid,
   input logic [1:0]      s_bresp,
   input logic            m_awvalid,
   input logic            m_awready,
   input logic [NA_W-1:0] m_awaddr,
   input logic            m_wvalid,
   input logic            m_wready,
   input logic            m_bvalid,
   input logic            m_bready
);
   logic [ID_W-1:0] id_seen;
   logic            aw_pend, w_pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         id_seen <= '0;
         aw_pend <= 1'b0;
         w_pend  <= 1'b0;
      end else begin
         if (s_awvalid && s_awready) id_seen <= s_awid;
         if (m_bvalid && m_bready) begin
            aw_pend <= 1'b0;
            w_pend  <= 1'b0;
         end else begin
            if (m_awvalid && m_awready) aw_pend <= 1'b1;
            if (m_wvalid && m_wready)   w_pend  <= 1'b1;
         end
      end
   end

   AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      (s_awvalid && s_awready) |=> !s_awready); // R1
   AST_BID_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      s_bvalid |-> (s_bid == id_seen)); // R2
   AST_BRESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (s_bvalid && !s_bready) |=> (s_bvalid && $stable(s_bresp) && $stable(s_bid))); // R9
   AST_LITE_AW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr))); // R12
   AST_LITE_W_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (m_wvalid && !m_wready) |=> m_wvalid); // R12
   AST_LITE_B_AFTER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      m_bready |-> (aw_pend && w_pend)); // R12
   AST_NO_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      aw_pend |-> !m_awvalid); // R12
   AST_RESET_IDLE: assert property (@(posedge clk)
      !rst_n |=> (s_awready && !s_bvalid)); // R13

   generate
      if (SPLIT) begin : g_split_chk
         AST_SPLIT_NO_DECERR: assert property (@(posedge clk) disable iff (!rst_n)
            s_bvalid |-> (s_bresp != 2'b11)); // R9
      end
   endgenerate
endmodule

bind axi_wr_narrow axwn_chk #(
   .ID_W  (ID_W),
   .NA_W  (NA_W),
   .SPLIT (WD_W != ND_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .s_awvalid (s_awvalid),
   .s_awready (s_awready),
   .s_awid    (s_awid),
   .s_bvalid  (s_bvalid),
   .s_bready  (s_bready),
   .s_bid     (s_bid),
   .s_bresp   (s_bresp),
   .m_awvalid (m_awvalid),
   .m_awready (m_awready),
   .m_awaddr  (m_awaddr),
   .m_wvalid  (m_wvalid),
   .m_wready  (m_wready),
   .m_bvalid  (m_bvalid),
   .m_bready  (m_bready)
);

// File: tb/tb_axi_wr_narrow.sv
`timescale 1ns/1ps
module tb_axi_wr_narrow;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic        s_awvalid = 0;
   logic [3:0]  s_awid = 0;
   logic [31:0] s_awaddr = 0;
   logic [7:0]  s_awlen = 0;
   logic [2:0]  s_awsize = 0;
   logic [1:0]  s_awburst = 0;
   logic [2:0]  s_awprot = 0;
   logic        s_wvalid = 0;
   logic [31:0] s_wdata = 0;
   logic [3:0]  s_wstrb = 0;
   logic        s_bready = 0;
   logic        m_awready = 0;
   logic        m_wready = 0;
   logic        m_bvalid = 0;
   logic [1:0]  m_bresp = 0;

   logic        sp_awready, sp_wready, sp_bvalid, sp_mawvalid, sp_mwvalid, sp_mbready;
   logic [3:0]  sp_bid;
   logic [1:0]  sp_bresp;
   logic [23:0] sp_mawaddr;
   logic [2:0]  sp_mawprot;
   logic [15:0] sp_mwdata;
   logic [1:0]  sp_mwstrb;

   logic        eq_awready, eq_wready, eq_bvalid, eq_mawvalid, eq_mwvalid, eq_mbready;
   logic [3:0]  eq_bid;
   logic [1:0]  eq_bresp;
   logic [23:0] eq_mawaddr;
   logic [2:0]  eq_mawprot;
   logic [31:0] eq_mwdata;
   logic [3:0]  eq_mwstrb;

   axi_wr_narrow dut (
      .clk(clk), .rst_n(rst_n),
      .s_awvalid(s_awvalid), .s_awready(sp_awready), .s_awid(s_awid), .s_awaddr(s_awaddr),
      .s_awlen(s_awlen), .s_awsize(s_awsize), .s_awburst(s_awburst), .s_awprot(s_awprot),
      .s_wvalid(s_wvalid), .s_wready(sp_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
      .s_bvalid(sp_bvalid), .s_bready(s_bready), .s_bid(sp_bid), .s_bresp(sp_bresp),
      .m_awvalid(sp_mawvalid), .m_awready(m_awready), .m_awaddr(sp_mawaddr), .m_awprot(sp_mawprot),
      .m_wvalid(sp_mwvalid), .m_wready(m_wready), .m_wdata(sp_mwdata), .m_wstrb(sp_mwstrb),
      .m_bvalid(m_bvalid), .m_bready(sp_mbready), .m_bresp(m_bresp)
   );

   axi_wr_narrow #(.ND_W(32)) dut_eq (
      .clk(clk), .rst_n(rst_n),
      .s_awvalid(s_awvalid), .s_awready(eq_awready), .s_awid(s_awid), .s_awaddr(s_awaddr),
      .s_awlen(s_awlen), .s_awsize(s_awsize), .s_awburst(s_awburst), .s_awprot(s_awprot),
      .s_wvalid(s_wvalid), .s_wready(eq_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
      .s_bvalid(eq_bvalid), .s_bready(s_bready), .s_bid(eq_bid), .s_bresp(eq_bresp),
      .m_awvalid(eq_mawvalid), .m_awready(m_awready), .m_awaddr(eq_mawaddr), .m_awprot(eq_mawprot),
      .m_wvalid(eq_mwvalid), .m_wready(m_wready), .m_wdata(eq_mwdata), .m_wstrb(eq_mwstrb),
      .m_bvalid(m_bvalid), .m_bready(eq_mbready), .m_bresp(m_bresp)
   );

   bit mode = 1'b0;   // 0: split instance, 1: equal-width instance
   logic        o_awready, o_wready, o_bvalid, o_mawvalid, o_mwvalid, o_mbready;
   logic [3:0]  o_bid, o_mwstrb;
   logic [1:0]  o_bresp;
   logic [23:0] o_mawaddr;
   logic [2:0]  o_mawprot;
   logic [31:0] o_mwdata;

   assign o_awready  = mode ? eq_awready  : sp_awready;
   assign o_wready   = mode ? eq_wready   : sp_wready;
   assign o_bvalid   = mode ? eq_bvalid   : sp_bvalid;
   assign o_mawvalid = mode ? eq_mawvalid : sp_mawvalid;
   assign o_mwvalid  = mode ? eq_mwvalid  : sp_mwvalid;
   assign o_mbready  = mode ? eq_mbready  : sp_mbready;
   assign o_bid      = mode ? eq_bid      : sp_bid;
   assign o_bresp    = mode ? eq_bresp    : sp_bresp;
   assign o_mawaddr  = mode ? eq_mawaddr  : sp_mawaddr;
   assign o_mawprot  = mode ? eq_mawprot  : sp_mawprot;
   assign o_mwdata   = mode ? eq_mwdata   : {16'h0, sp_mwdata};
   assign o_mwstrb   = mode ? eq_mwstrb   : {2'b00, sp_mwstrb};

   int n_vec = 0;
   int n_bad = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   logic [23:0] ex_addr [0:1023];
   logic [31:0] ex_data [0:1023];
   logic [3:0]  ex_strb [0:1023];
   int          n_exp;
   logic [31:0] bd [0:15];
   logic [3:0]  bs [0:15];

   // Expected child list from the requirements (R3..R8, R10)
   task automatic build_expect(input logic [31:0] start, input int len, input int size,
                               input logic [1:0] burst, input int nsb);
      logic [31:0] a, total, wbase, step, cbase, cend, caddr, n;
      int fs, ls, lane;
      a = start;
      total = (len + 1) << size;
      wbase = start & ~(total - 1);
      n_exp = 0;
      for (int b = 0; b <= len; b++) begin
         step  = 32'd1 << size;
         cbase = a & ~(step - 1);
         cend  = cbase + step;
         fs = int'(a / nsb);
         ls = int'((cend - 1) / nsb);
         for (int s = fs; s <= ls; s++) begin
            caddr = (s == fs) ? a : 32'(s * nsb);
            lane  = (s * nsb) % 4;
            ex_addr[n_exp] = caddr[23:0];
            ex_data[n_exp] = (nsb == 4) ? bd[b] : ((bd[b] >> (lane * 8)) & 32'hFFFF);
            ex_strb[n_exp] = (nsb == 4) ? bs[b] : ((bs[b] >> lane) & 4'h3);
            n_exp++;
         end
         if (burst == 2'b00) n = a;
         else if (burst == 2'b10) begin
            n = cend;
            if (n >= wbase + total) n = wbase;
         end else n = cend;
         a = n;
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      s_awvalid = 0; s_wvalid = 0; s_bready = 0;
      m_awready = 0; m_wready = 0; m_bvalid = 0;
      repeat (3) @(negedge clk);
      chk(o_awready === 1'b1, "R13", "awready in reset", 32'(o_awready), 1);
      chk(o_bvalid === 1'b0 && o_mawvalid === 1'b0 && o_mwvalid === 1'b0, "R13",
          "valids in reset", {o_bvalid, o_mawvalid, o_mwvalid}, 0);
      rst_n = 1'b1;
   endtask

   // errmode: 0 all OKAY, 1 random errors, 2 one forced code on child force_idx
   task automatic run_burst(input logic [3:0] id, input logic [31:0] addr, input int len,
                            input int size, input logic [1:0] burst, input logic [2:0] prot,
                            input int errmode, input logic [1:0] force_code, input int force_idx);
      int nsb, wb, nchild, cyc, r;
      bit aw_sent, awc, wc, bact, done, busy_ready, early_b, reissue;
      logic [23:0] c_addr; logic [2:0] c_prot; logic [31:0] c_data; logic [3:0] c_strb;
      logic [1:0] cur_resp, exp_resp;
      string tag;
      nsb = mode ? 4 : 2;
      for (int b = 0; b < 16; b++) begin
         bd[b] = $urandom;
         bs[b] = 4'($urandom);
      end
      build_expect(addr, len, size, burst, nsb);
      tag = (burst == 2'b00) ? "R3 R7" : (burst == 2'b10) ? "R3 R8" : "R3 R6";
      wb = 0; nchild = 0; cyc = 0;
      aw_sent = 0; awc = 0; wc = 0; bact = 0; done = 0;
      busy_ready = 0; early_b = 0; reissue = 0;
      cur_resp = 0; exp_resp = 0;
      c_addr = 0; c_prot = 0; c_data = 0; c_strb = 0;
      while (!done) begin
         @(negedge clk);
         cyc++;
         if (cyc > 4000) begin
            chk(0, "R4", "watchdog on burst", 32'(nchild), 32'(n_exp));
            done = 1;
            break;
         end
         if (awc && wc && !bact) begin
            bact = 1;
            if (nchild < n_exp) begin
               chk(c_addr == ex_addr[nchild], tag, "child address", 32'(c_addr), 32'(ex_addr[nchild]));
               chk(c_data == ex_data[nchild], "R5", "child data", c_data, ex_data[nchild]);
               chk(c_strb == ex_strb[nchild], "R5", "child strobe", 32'(c_strb), 32'(ex_strb[nchild]));
               chk(c_prot == prot, "R11", "child prot", 32'(c_prot), 32'(prot));
            end else
               chk(0, "R4", "extra child", 32'(nchild + 1), 32'(n_exp));
            if (errmode == 1) begin
               r = int'($urandom % 10);
               cur_resp = (r == 0) ? 2'b10 : (r == 1) ? 2'b11 : 2'b00;
            end else if (errmode == 2 && nchild == force_idx) cur_resp = force_code;
            else cur_resp = 2'b00;
         end
         if (o_mbready && !(awc && wc)) early_b = 1;
         if (o_mawvalid && awc) reissue = 1;
         if (aw_sent && o_awready) busy_ready = 1;
         // drive
         s_awvalid = !aw_sent;
         s_awid = id; s_awaddr = addr; s_awlen = 8'(len); s_awsize = 3'(size);
         s_awburst = burst; s_awprot = prot;
         s_wvalid = (wb <= len) && ($urandom % 4 != 0);
         s_wdata = (wb <= len) ? bd[wb] : 32'h0;
         s_wstrb = (wb <= len) ? bs[wb] : 4'h0;
         m_awready = ($urandom % 3 != 0);
         m_wready = ($urandom % 3 != 0);
         m_bvalid = bact;
         m_bresp = cur_resp;
         s_bready = ($urandom % 3 != 0);
         // handshakes at the coming edge
         if (s_awvalid && o_awready) aw_sent = 1;
         if (s_wvalid && o_wready) wb++;
         if (o_mawvalid && m_awready) begin c_addr = o_mawaddr; c_prot = o_mawprot; awc = 1; end
         if (o_mwvalid && m_wready) begin c_data = o_mwdata; c_strb = o_mwstrb; wc = 1; end
         if (bact && o_mbready) begin
            if (mode) begin
               if (exp_resp == 2'b00) exp_resp = cur_resp;
            end else if (cur_resp[1]) exp_resp = 2'b10;
            bact = 0; awc = 0; wc = 0; nchild++;
         end
         if (o_bvalid && s_bready) begin
            chk(o_bid == id, "R2", "returned id", 32'(o_bid), 32'(id));
            chk(o_bresp == exp_resp, mode ? "R10" : "R9", "burst response", 32'(o_bresp), 32'(exp_resp));
            chk(nchild == n_exp && wb == len + 1, "R4", "children and beats",
                32'(nchild), 32'(n_exp));
            done = 1;
         end
      end
      @(negedge clk);
      s_awvalid = 0; s_wvalid = 0; s_bready = 0; m_bvalid = 0;
      chk(!busy_ready, "R1", "awready while busy", 32'(busy_ready), 0);
      chk(!early_b && !reissue, "R12", "narrow handshake order", {early_b, reissue}, 0);
   endtask

   task automatic rand_burst(input int errmode);
      int size, len, kind;
      logic [1:0] bt;
      size = int'($urandom % 3);
      kind = int'($urandom % 3);
      bt = 2'(kind);
      if (bt == 2'b10) len = (2 << ($urandom % 4)) - 1;
      else len = int'($urandom % 16);
      run_burst(4'($urandom), {$urandom} & 32'h00FF_FFFF, len, size, bt, 3'($urandom),
                errmode, 2'b00, 0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      mode = 0;
      do_reset();
      // directed corner cases, split instance
      run_burst(4'h3, 32'h100, 3, 2, 2'b01, 3'h2, 0, 2'b00, 0);  // R6 aligned incr
      run_burst(4'h5, 32'h103, 2, 2, 2'b01, 3'h1, 0, 2'b00, 0);  // R3 unaligned first beat
      run_burst(4'h7, 32'h206, 2, 1, 2'b00, 3'h4, 0, 2'b00, 0);  // R7 fixed
      run_burst(4'h9, 32'h38,  3, 2, 2'b10, 3'h0, 0, 2'b00, 0);  // R8 wrap mid-container
      run_burst(4'hA, 32'h4A,  7, 1, 2'b10, 3'h6, 0, 2'b00, 0);  // R8 halfword wrap
      run_burst(4'hB, 32'h13,  3, 0, 2'b01, 3'h0, 0, 2'b00, 0);  // R4 byte beats, one child
      run_burst(4'hC, 32'h40,  1, 2, 2'b01, 3'h0, 2, 2'b11, 1);  // R9 DECERR folds to SLVERR
      run_burst(4'hD, 32'h80,  2, 2, 2'b01, 3'h0, 2, 2'b10, 0);  // R9 sticky from first child
      for (int i = 0; i < 40; i++) rand_burst(1);
      mode = 1;
      do_reset();
      run_burst(4'h2, 32'h60, 1, 2, 2'b01, 3'h3, 2, 2'b11, 0);   // R10 DECERR passes through
      run_burst(4'h4, 32'h61, 3, 2, 2'b01, 3'h5, 2, 2'b10, 2);   // R10 SLVERR on later beat
      run_burst(4'h6, 32'h1C, 3, 2, 2'b10, 3'h1, 0, 2'b00, 0);   // R10 wrap, one child per beat
      for (int i = 0; i < 20; i++) rand_burst(1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #950000;
      n_vec++;
      n_bad++;
      $display("FAIL R1 global watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule